// File: doc/BRIEF.md
# Halt and Reset-Cause Controller

This controller sequences power-down entry and exit for a small processor and decides what kind of reset, if any, follows a wake-up. A halt strobe from the core stops the system clock enable, raises the power-down flag, drops the time-out flag and tells the watchdog to clear itself and its prescaler. While halted, the watchdog oscillator is kept running if it is the selected watchdog source. An interrupt request, a falling edge on a watched port pin, a watchdog overflow or an external reset request ends the halt.

The two status flags record why the chip restarted. An external reset gives a full initialization with both flags clear. A watchdog overflow in normal operation gives a full chip reset with the time-out flag set. A watchdog overflow while halted gives only a warm reset of the program counter and stack pointer, with both flags set. An interrupt or a pin edge resumes execution with no reset at all. The core, the interrupt controller and clock generation sit outside this block.

Top module: `halt_reset_ctrl`

## Requirements
- R1: After `rst`, `sys_clk_en_o`=1, `pd_flag_o`=0, `to_flag_o`=0, and `chip_rst_o`, `warm_rst_o`, `wdt_clr_o` are all 0.
- R2: A `halt_req_i` cycle while running (with no reset request or overflow edge in that cycle) makes, one clock later, `sys_clk_en_o`=0, `pd_flag_o`=1, `to_flag_o`=0 and a one-cycle `wdt_clr_o` pulse with no reset pulse; a `halt_req_i` while already halted produces no `wdt_clr_o` and keeps the block halted.
- R3: `wdt_osc_run_o` is 1 while running; while halted it equals `wdt_osc_sel_i`.
- R4: A rising edge on `ext_rst_i` has top priority: one clock later `chip_rst_o` pulses, `sys_clk_en_o`=1 and both flags are 0, whether running or halted.
- R5: A rising edge on `wdt_tout_i` while running (no external edge) gives, one clock later, a `chip_rst_o` pulse, `to_flag_o`=1, `pd_flag_o`=0 and no `warm_rst_o`; it wins over a `halt_req_i` in the same cycle, so no halt is entered.
- R6: A rising edge on `wdt_tout_i` while halted gives, one clock later, a `warm_rst_o` pulse only (no `chip_rst_o`), `sys_clk_en_o`=1, `pd_flag_o`=1 and `to_flag_o`=1.
- R7: `irq_i`=1 while halted restores `sys_clk_en_o` one clock later with no reset pulse and unchanged flags (`pd_flag_o`=1, `to_flag_o`=0).
- R8: A 1-to-0 change on `port_i` while halted passes a two-flop synchronizer and edge detector; `sys_clk_en_o` is still 0 after the second rising clock edge and is 1 after the third, with no reset pulse.
- R9: `irq_i` or a falling `port_i` while running has no effect on clock enable, flags or reset outputs, and a pin fall completed before halt entry does not wake the block.
- R10: A level held high on `ext_rst_i` or `wdt_tout_i` yields a single one-cycle reset pulse, not a train.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| halt_req_i | input | 1 | Halt instruction strobe from the core |
| ext_rst_i | input | 1 | External reset request (rising edge acts) |
| irq_i | input | 1 | Interrupt request level |
| port_i | input | 1 | Asynchronous port pin watched for falling edges |
| wdt_tout_i | input | 1 | Watchdog overflow (rising edge acts) |
| wdt_osc_sel_i | input | 1 | Watchdog runs from its own oscillator |
| sys_clk_en_o | output | 1 | System clock enable |
| chip_rst_o | output | 1 | One-cycle full chip reset pulse |
| warm_rst_o | output | 1 | One-cycle PC/SP-only reset pulse |
| wdt_clr_o | output | 1 | One-cycle watchdog and prescaler clear |
| pd_flag_o | output | 1 | Power-down status flag |
| to_flag_o | output | 1 | Time-out status flag |
| wdt_osc_run_o | output | 1 | Watchdog oscillator path enable |

## Verification
The two functions that can coincide are halt entry and a watchdog overflow edge, and likewise an external reset edge with an overflow. The bench raises `halt_req_i` and `wdt_tout_i` in the same cycle, and `ext_rst_i` with `wdt_tout_i` in the same cycle, both directed and inside the random scenario mix. It judges the outcome by checking that the overflow wins over the halt (full reset, time-out flag set, no clear strobe, clock still enabled) and that the external reset wins over the overflow (both flags clear).

// File: rtl/hrc_pkg.sv
package hrc_pkg;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } pwr_state_e;

    // Qualified events presented to the sequencer in one cycle
    typedef struct packed {
        logic ext_rst;
        logic wdt_ovf;
        logic irq;
        logic port_fall;
        logic halt_req;
    } wake_evt_t;

    typedef enum logic [2:0] {
        ACT_NONE       = 3'd0,
        ACT_ENTER_HALT = 3'd1,
        ACT_WAKE       = 3'd2,
        ACT_FULL_EXT   = 3'd3,
        ACT_FULL_WDT   = 3'd4,
        ACT_WARM       = 3'd5
    } action_e;

    // Fixed priority: external reset, then watchdog, then wake, then halt.
    function automatic action_e pick_action(input pwr_state_e st, input wake_evt_t ev);
        action_e a;
        a = ACT_NONE;
        if (ev.ext_rst) begin
            a = ACT_FULL_EXT;
        end else if (ev.wdt_ovf) begin
            a = (st == ST_HALT) ? ACT_WARM : ACT_FULL_WDT;
        end else if (st == ST_HALT) begin
            if (ev.irq || ev.port_fall) a = ACT_WAKE;
        end else if (ev.halt_req) begin
            a = ACT_ENTER_HALT;
        end
        return a;
    endfunction

endpackage

// File: rtl/hrc_sync.sv
module hrc_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= RESET_VAL;
                    else     chain_q[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= RESET_VAL;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/hrc_edge_det.sv
module hrc_edge_det #(
    parameter bit RISING    = 1'b1,
    parameter bit RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic pulse
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= RESET_VAL;
        else     prev_q <= d;
    end

    generate
        if (RISING) begin : g_rise
            assign pulse = d & ~prev_q;
        end else begin : g_fall
            assign pulse = prev_q & ~d;
        end
    endgenerate

    // A held level must not re-trigger the detector on the next cycle
    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        (pulse && $stable(d)) |=> !pulse);
endmodule

// File: rtl/hrc_seq.sv
module hrc_seq
    import hrc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  wake_evt_t ev,
    output logic      halted_o,
    output logic      chip_rst_o,
    output logic      warm_rst_o,
    output logic      wdt_clr_o,
    output logic      pd_o,
    output logic      to_o
);
    pwr_state_e st_q;
    action_e    act;
    logic       chip_rst_q, warm_rst_q, wdt_clr_q, pd_q, to_q;

    assign act = pick_action(st_q, ev);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_RUN;
            chip_rst_q <= 1'b0;
            warm_rst_q <= 1'b0;
            wdt_clr_q  <= 1'b0;
            pd_q       <= 1'b0;
            to_q       <= 1'b0;
        end else begin
            chip_rst_q <= 1'b0;
            warm_rst_q <= 1'b0;
            wdt_clr_q  <= 1'b0;
            case (act)
                ACT_FULL_EXT: begin
                    st_q       <= ST_RUN;
                    chip_rst_q <= 1'b1;
                    pd_q       <= 1'b0;
                    to_q       <= 1'b0;
                end
                ACT_FULL_WDT: begin
                    st_q       <= ST_RUN;
                    chip_rst_q <= 1'b1;
                    pd_q       <= 1'b0;
                    to_q       <= 1'b1;
                end
                ACT_WARM: begin
                    st_q       <= ST_RUN;
                    warm_rst_q <= 1'b1;
                    to_q       <= 1'b1;
                end
                ACT_WAKE: begin
                    st_q <= ST_RUN;
                end
                ACT_ENTER_HALT: begin
                    st_q      <= ST_HALT;
                    pd_q      <= 1'b1;
                    to_q      <= 1'b0;
                    wdt_clr_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign halted_o   = (st_q == ST_HALT);
    assign chip_rst_o = chip_rst_q;
    assign warm_rst_o = warm_rst_q;
    assign wdt_clr_o  = wdt_clr_q;
    assign pd_o       = pd_q;
    assign to_o       = to_q;

    assert_halt_entry_R2: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RUN && ev.halt_req && !ev.ext_rst && !ev.wdt_ovf)
        |=> (halted_o && pd_q && !to_q && wdt_clr_q && !chip_rst_q && !warm_rst_q));

    assert_ext_reset_R4: assert property (@(posedge clk) disable iff (rst)
        ev.ext_rst |=> (chip_rst_q && !warm_rst_q && !pd_q && !to_q && !halted_o));

    assert_wdt_run_R5: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RUN && ev.wdt_ovf && !ev.ext_rst)
        |=> (chip_rst_q && !warm_rst_q && to_q && !pd_q && !halted_o && !wdt_clr_q));

    assert_wdt_halt_R6: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_HALT && ev.wdt_ovf && !ev.ext_rst)
        |=> (warm_rst_q && !chip_rst_q && to_q && pd_q && !halted_o));

    assert_quiet_wake_R7: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_HALT && (ev.irq || ev.port_fall) && !ev.ext_rst && !ev.wdt_ovf)
        |=> (!halted_o && !chip_rst_q && !warm_rst_q && $stable(pd_q) && $stable(to_q)));

    assert_halt_no_reclear_R2: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_HALT && !ev.ext_rst && !ev.wdt_ovf && !ev.irq && !ev.port_fall)
        |=> (halted_o && !wdt_clr_q));

    assert_rst_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        !(chip_rst_q && warm_rst_q));
endmodule

// File: rtl/halt_reset_ctrl.sv
module halt_reset_ctrl
    import hrc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic halt_req_i,
    input  logic ext_rst_i,
    input  logic irq_i,
    input  logic port_i,
    input  logic wdt_tout_i,
    input  logic wdt_osc_sel_i,
    output logic sys_clk_en_o,
    output logic chip_rst_o,
    output logic warm_rst_o,
    output logic wdt_clr_o,
    output logic pd_flag_o,
    output logic to_flag_o,
    output logic wdt_osc_run_o
);
    logic      port_sync, port_fall, ext_edge, wdt_edge, halted;
    wake_evt_t ev;

    hrc_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_port_sync (
        .clk(clk), .rst(rst), .d(port_i), .q(port_sync)
    );

    hrc_edge_det #(.RISING(1'b0), .RESET_VAL(1'b1)) u_port_fall (
        .clk(clk), .rst(rst), .d(port_sync), .pulse(port_fall)
    );

    hrc_edge_det #(.RISING(1'b1), .RESET_VAL(1'b0)) u_ext_edge (
        .clk(clk), .rst(rst), .d(ext_rst_i), .pulse(ext_edge)
    );

    hrc_edge_det #(.RISING(1'b1), .RESET_VAL(1'b0)) u_wdt_edge (
        .clk(clk), .rst(rst), .d(wdt_tout_i), .pulse(wdt_edge)
    );

    always_comb begin
        ev.ext_rst   = ext_edge;
        ev.wdt_ovf   = wdt_edge;
        ev.irq       = irq_i;
        ev.port_fall = port_fall;
        ev.halt_req  = halt_req_i;
    end

    hrc_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .halted_o   (halted),
        .chip_rst_o (chip_rst_o),
        .warm_rst_o (warm_rst_o),
        .wdt_clr_o  (wdt_clr_o),
        .pd_o       (pd_flag_o),
        .to_o       (to_flag_o)
    );

    assign sys_clk_en_o  = ~halted;
    assign wdt_osc_run_o = ~halted | wdt_osc_sel_i;

    // Interrupt or pin activity while running must leave the block running
    assert_run_ignores_wake_R9: assert property (@(posedge clk) disable iff (rst)
        (!halted && !halt_req_i && !ext_edge && !wdt_edge)
        |=> (sys_clk_en_o && !chip_rst_o && !warm_rst_o && $stable(pd_flag_o) && $stable(to_flag_o)));
endmodule

// File: tb/halt_reset_ctrl_tb_top.sv
module halt_reset_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst;
    logic halt_req, ext_rst, irq, port, wdt_tout, osc_sel;
    logic clk_en, chip_rst, warm_rst, wdt_clr, pd, to, osc_run;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    halt_reset_ctrl dut_i (
        .clk(clk), .rst(rst), .halt_req_i(halt_req), .ext_rst_i(ext_rst),
        .irq_i(irq), .port_i(port), .wdt_tout_i(wdt_tout), .wdt_osc_sel_i(osc_sel),
        .sys_clk_en_o(clk_en), .chip_rst_o(chip_rst), .warm_rst_o(warm_rst),
        .wdt_clr_o(wdt_clr), .pd_flag_o(pd), .to_flag_o(to), .wdt_osc_run_o(osc_run)
    );

    task automatic chk(input string req, input string what, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Scenario kinds: 0 irq wake, 1 wdt in halt, 2 wdt running, 3 ext in halt,
    // 4 ext running, 5 halt+wdt same cycle, 6 pin wake, 7 ext+wdt same cycle
    function automatic logic [1:0] exp_flags(input int k);
        case (k)
            0, 6:    return 2'b10;
            1:       return 2'b11;
            2, 5:    return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic exp_chip(input int k);
        return (k != 0 && k != 1 && k != 6);
    endfunction

    function automatic logic exp_warm(input int k);
        return (k == 1);
    endfunction

    task automatic enter_halt();
        halt_req = 1'b1;
        step();
        halt_req = 1'b0;
        chk("R2", "clk_en after halt", clk_en, 1'b0);
        chk("R2", "pd after halt", pd, 1'b1);
        chk("R2", "to after halt", to, 1'b0);
        chk("R2", "wdt_clr pulse", wdt_clr, 1'b1);
        chk("R2", "no chip_rst on halt", chip_rst, 1'b0);
        step();
        chk("R2", "wdt_clr one cycle", wdt_clr, 1'b0);
    endtask

    task automatic run_kind(input int k, input int gap);
        case (k)
            0: begin
                enter_halt();
                repeat (gap) step();
                irq = 1'b1; step(); irq = 1'b0;
            end
            1: begin
                enter_halt();
                repeat (gap) step();
                wdt_tout = 1'b1; step(); wdt_tout = 1'b0;
            end
            2: begin
                wdt_tout = 1'b1; step(); wdt_tout = 1'b0;
            end
            3: begin
                enter_halt();
                repeat (gap) step();
                ext_rst = 1'b1; step(); ext_rst = 1'b0;
            end
            4: begin
                ext_rst = 1'b1; step(); ext_rst = 1'b0;
            end
            5: begin
                halt_req = 1'b1; wdt_tout = 1'b1; step();
                halt_req = 1'b0; wdt_tout = 1'b0;
                chk("R5", "no wdt_clr when overflow wins", wdt_clr, 1'b0);
            end
            6: begin
                enter_halt();
                repeat (gap) step();
                port = 1'b0; step(); step();
                chk("R8", "still halted after two edges", clk_en, 1'b0);
                step();
            end
            default: begin
                ext_rst = 1'b1; wdt_tout = 1'b1; step();
                ext_rst = 1'b0; wdt_tout = 1'b0;
            end
        endcase
        chk("R4", $sformatf("clk_en after kind %0d", k), clk_en, 1'b1);
        chk("R5", $sformatf("chip_rst kind %0d", k), chip_rst, exp_chip(k));
        chk("R6", $sformatf("warm_rst kind %0d", k), warm_rst, exp_warm(k));
        chk("R7", $sformatf("pd kind %0d", k), pd, exp_flags(k)[1]);
        chk("R6", $sformatf("to kind %0d", k), to, exp_flags(k)[0]);
        step();
        chk("R10", "chip_rst dropped", chip_rst, 1'b0);
        chk("R10", "warm_rst dropped", warm_rst, 1'b0);
        if (k == 6) begin
            port = 1'b1;
            repeat (4) step();
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        int seed_val;
        seed_val = $urandom(32'd2024);
        rst = 1'b1; halt_req = 1'b0; ext_rst = 1'b0; irq = 1'b0;
        port = 1'b1; wdt_tout = 1'b0; osc_sel = 1'b1;
        @(negedge clk);
        step(); step();
        rst = 1'b0;
        step();

        // R1 reset state
        chk("R1", "clk_en", clk_en, 1'b1);
        chk("R1", "pd", pd, 1'b0);
        chk("R1", "to", to, 1'b0);
        chk("R1", "chip_rst", chip_rst, 1'b0);
        chk("R1", "warm_rst", warm_rst, 1'b0);
        chk("R1", "wdt_clr", wdt_clr, 1'b0);

        // R9 irq and pin fall while running
        irq = 1'b1; port = 1'b0;
        repeat (5) step();
        irq = 1'b0;
        chk("R9", "clk_en running", clk_en, 1'b1);
        chk("R9", "pd running", pd, 1'b0);
        chk("R9", "no reset running", chip_rst | warm_rst, 1'b0);
        // R9 pin already low before halt: no wake
        enter_halt();
        repeat (4) step();
        chk("R9", "stale pin fall no wake", clk_en, 1'b0);
        // R2 halt strobe while halted
        halt_req = 1'b1; step(); halt_req = 1'b0;
        chk("R2", "no reclear in halt", wdt_clr, 1'b0);
        chk("R2", "stays halted", clk_en, 1'b0);
        // R3 oscillator path in halt
        osc_sel = 1'b0; #1;
        chk("R3", "osc off when not selected", osc_run, 1'b0);
        osc_sel = 1'b1; #1;
        chk("R3", "osc on when selected", osc_run, 1'b1);
        irq = 1'b1; step(); irq = 1'b0;
        chk("R7", "irq wake", clk_en, 1'b1);
        osc_sel = 1'b0; #1;
        chk("R3", "osc on while running", osc_run, 1'b1);
        osc_sel = 1'b1;
        port = 1'b1;
        repeat (4) step();

        // R10 held reset level gives a single pulse
        ext_rst = 1'b1; step();
        chk("R10", "ext held first pulse", chip_rst, 1'b1);
        step();
        chk("R10", "ext held no second pulse", chip_rst, 1'b0);
        step();
        chk("R10", "ext held still quiet", chip_rst, 1'b0);
        ext_rst = 1'b0;
        wdt_tout = 1'b1; step();
        chk("R10", "wdt held first pulse", chip_rst, 1'b1);
        step();
        chk("R10", "wdt held no second pulse", chip_rst, 1'b0);
        wdt_tout = 1'b0; step();

        // Directed pass over every scenario, then random mix
        for (int k = 0; k < 8; k++) run_kind(k, 1);
        for (int i = 0; i < 60; i++) begin
            int k;
            int gap;
            k   = int'($urandom_range(0, 7));
            gap = int'($urandom_range(0, 4));
            repeat (int'($urandom_range(0, 3))) step();
            run_kind(k, gap);
        end
        finish_run();
    end
endmodule